// File: doc/BRIEF.md
# Dual-Width Read Output Controller

This block is the synchronous read-side output stage of a 16-bit memory. A 16-bit read word comes in from the storage array. The block then decides what, if anything, appears on a 16-bit data bus split into two byte lanes. Every lane has its own enable flag, which stands in for a tristate driver. A lane whose flag is low is released and carries zero.

Both enables are active low and are sampled on the system clock. A two-bit source select picks one of three data sources: the array word, a fixed identifier word, or a status byte. Word mode drives the whole word. Byte mode drives only the low lane, and the top data pin acts as an extra low-order address bit that picks which half of the word goes onto that lane.

The status byte is frozen at the start of each access, so a reader always sees one consistent value. The start of an access is the clock on which both enables are first seen asserted, which is the later of the two falling edges. Status changes made during the access stay hidden until an enable is toggled.

Top module: `rd_out_ctrl`

## Requirements
- R1: When either `ce_n` or `oe_n` is sampled high, the next cycle shows `lane_en` = 2'b00 and `dout` = 0. This holds whatever the other inputs are doing.
- R2: In word mode (`byte_mode` = 0) with both enables low, the next cycle shows `lane_en` = 2'b11. `dout[7:0]` carries bits 7:0 of the selected source word, and `dout[15:8]` carries bits 15:8, including bit 15.
- R3: In byte mode (`byte_mode` = 1) with both enables low, the high lane is released: `lane_en[1]` = 0 and `dout[15:8]` = 0, while `lane_en[0]` = 1.
- R4: In byte mode, `top_pin` = 1 puts bits 15:8 of the source word on `dout[7:0]`, and `top_pin` = 0 puts bits 7:0 there.
- R5: With `src` = 2'b01 (identifier), the source word is 16'h00C2 when `addr0` = 0 and 16'h006A when `addr0` = 1.
- R6: With `src` = 2'b10 (status), the source word has the upper byte 00h. In the lower byte, bit 7 = `stat_ready`, bit 4 = `stat_fail`, and every other bit is 0. `src` = 2'b00 and 2'b11 both select `rd_word`.
- R7: The status byte is captured on the cycle where both enables are sampled low after a cycle where at least one was high. The capture happens whatever `src` is. While both enables stay low, changes on `stat_ready` and `stat_fail` do not reach `dout`; a new value shows only after an enable goes high and comes low again.
- R8: Outputs are registered. Each result appears one clock after the inputs that produce it. After reset, `lane_en` = 2'b00 and `dout` = 0, and the status snapshot is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = byte-wide output, 0 = word-wide output |
| top_pin | input | 1 | In byte mode, selects the upper (1) or lower (0) half of the word |
| src | input | 2 | Data source: 00/11 array, 01 identifier, 10 status |
| addr0 | input | 1 | Selects the identifier code |
| rd_word | input | 16 | Word read from the array |
| stat_ready | input | 1 | Live ready flag (1 = ready) |
| stat_fail | input | 1 | Live program-failure flag |
| dout | output | 16 | Output data; released lanes read 0 |
| lane_en | output | 2 | Per-lane drive flags, bit 0 = low lane |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. The bench drives inputs on the falling edge. It updates its own model of the enable history and the status snapshot at the next rising edge, and compares at the falling edge after that. Inputs therefore never change within half a cycle of the sampling edge. The status checks rely on the same count: the capture cycle and the output cycle coincide. Directed sequences hold both enables low while the live status changes, then toggle an enable and look for the new value in the single cycle where it must first appear.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int WORD_W    = 16;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = WORD_W / LANE_W;
    localparam int READY_BIT = 7;
    localparam int FAIL_BIT  = 4;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [LANE_W-1:0]    lane_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;

    localparam lane_t MFR_CODE = 8'hC2;
    localparam lane_t DEV_CODE = 8'h6A;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'b00,
        SRC_IDENT  = 2'b01,
        SRC_STATUS = 2'b10,
        SRC_ALT    = 2'b11
    } src_e;

    typedef struct packed {
        logic ready;
        logic fail;
    } stat_t;

    typedef struct packed {
        logic act;   // both enables asserted this sample
        logic cap;   // access just began
    } en_t;

    function automatic lane_t pack_status(stat_t s);
        lane_t b;
        b            = '0;
        b[READY_BIT] = s.ready;
        b[FAIL_BIT]  = s.fail;
        return b;
    endfunction

    function automatic word_t ident_word(logic a0);
        return {{(WORD_W-LANE_W){1'b0}}, (a0 ? DEV_CODE : MFR_CODE)};
    endfunction

endpackage

// File: rtl/rdo_enable_track.sv
module rdo_enable_track
    import rdo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output en_t  en
);
    logic ce_q, oe_q;
    logic act_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= 1'b1;
            oe_q <= 1'b1;
        end else begin
            ce_q <= ce_n;
            oe_q <= oe_n;
        end
    end

    assign act_prev = ~ce_q & ~oe_q;
    assign en.act   = ~ce_n & ~oe_n;
    assign en.cap   = en.act & ~act_prev;

endmodule

// File: rtl/rdo_status_snap.sv
module rdo_status_snap
    import rdo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  stat_t live,
    output lane_t view
);
    lane_t snap_q;
    lane_t fresh;

    assign fresh = pack_status(live);
    // The value captured this cycle goes straight to the output stage.
    assign view  = cap ? fresh : snap_q;

    always_ff @(posedge clk) begin
        if (rst)      snap_q <= '0;
        else if (cap) snap_q <= fresh;
    end

endmodule

// File: rtl/rdo_lane_steer.sv
module rdo_lane_steer
    import rdo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  logic       byte_mode,
    input  logic       top_pin,
    input  src_e       src,
    input  logic       addr0,
    input  word_t      rd_word,
    input  lane_t      stat_byte,
    output word_t      dout,
    output lane_mask_t lane_en
);
    word_t sel_word;

    always_comb begin
        unique case (src)
            SRC_IDENT:  sel_word = ident_word(addr0);
            SRC_STATUS: sel_word = {{(WORD_W-LANE_W){1'b0}}, stat_byte};
            default:    sel_word = rd_word;
        endcase
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_t data_d;
        logic  en_d;

        if (g == 0) begin : g_low
            assign data_d = (byte_mode && top_pin) ? sel_word[WORD_W-1 -: LANE_W]
                                                   : sel_word[LANE_W-1:0];
            assign en_d   = act;
        end else begin : g_high
            assign data_d = sel_word[g*LANE_W +: LANE_W];
            assign en_d   = act & ~byte_mode;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_en[g]                <= 1'b0;
                dout[g*LANE_W +: LANE_W]  <= '0;
            end else begin
                lane_en[g]                <= en_d;
                dout[g*LANE_W +: LANE_W]  <= en_d ? data_d : '0;
            end
        end
    end

endmodule

// File: rtl/rd_out_ctrl.sv
module rd_out_ctrl
    import rdo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        byte_mode,
    input  logic        top_pin,
    input  logic [1:0]  src,
    input  logic        addr0,
    input  logic [15:0] rd_word,
    input  logic        stat_ready,
    input  logic        stat_fail,
    output logic [15:0] dout,
    output logic [1:0]  lane_en
);
    en_t   en;
    stat_t live;
    lane_t stat_view;

    assign live.ready = stat_ready;
    assign live.fail  = stat_fail;

    rdo_enable_track u_en (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .en   (en)
    );

    rdo_status_snap u_snap (
        .clk  (clk),
        .rst  (rst),
        .cap  (en.cap),
        .live (live),
        .view (stat_view)
    );

    rdo_lane_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .act       (en.act),
        .byte_mode (byte_mode),
        .top_pin   (top_pin),
        .src       (src_e'(src)),
        .addr0     (addr0),
        .rd_word   (rd_word),
        .stat_byte (stat_view),
        .dout      (dout),
        .lane_en   (lane_en)
    );

endmodule

// File: rtl/rdo_checker.sv
module rdo_checker (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        oe_n,
    input logic        byte_mode,
    input logic        top_pin,
    input logic [1:0]  src,
    input logic [7:0]  word_hi,
    input logic [15:0] dout,
    input logic [1:0]  lane_en
);
    // R1: either enable high releases both lanes on the next cycle
    a_r1_release: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> (lane_en == 2'b00 && dout == 16'h0));

    // R2: word mode drives both lanes
    a_r2_word_lanes: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && !byte_mode) |=> (lane_en == 2'b11));

    // R3: byte mode releases the high lane
    a_r3_high_released: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && byte_mode) |=> (lane_en == 2'b01 && dout[15:8] == 8'h0));

    // R4: byte mode with the top pin set steers the upper array byte down
    a_r4_upper_steer: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && byte_mode && top_pin && (src == 2'b00 || src == 2'b11))
        |=> (dout[7:0] == $past(word_hi)));

    // R7: status output is frozen while the access continues
    a_r7_status_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ce_n && !oe_n && !$past(ce_n) && !$past(oe_n)
         && src == 2'b10 && $past(src) == 2'b10
         && byte_mode == $past(byte_mode) && top_pin == $past(top_pin))
        |=> $stable(dout));

endmodule

bind rd_out_ctrl rdo_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .byte_mode (byte_mode),
    .top_pin   (top_pin),
    .src       (src),
    .word_hi   (rd_word[15:8]),
    .dout      (dout),
    .lane_en   (lane_en)
);

// File: tb/rd_out_ctrl_tb.sv
`timescale 1ns/1ps
module rd_out_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, byte_mode, top_pin, addr0, stat_ready, stat_fail;
    logic [1:0]  src;
    logic [15:0] rd_word;
    logic [15:0] dout;
    logic [1:0]  lane_en;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;

    // bench model state
    bit         m_prev_act;
    logic [7:0] m_snap;
    logic [15:0] exp_d;
    logic [1:0]  exp_l;

    always #2.5 clk = ~clk;

    rd_out_ctrl u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
        .top_pin(top_pin), .src(src), .addr0(addr0), .rd_word(rd_word),
        .stat_ready(stat_ready), .stat_fail(stat_fail), .dout(dout), .lane_en(lane_en)
    );

    function automatic logic [15:0] src_word(logic [1:0] s, logic a0, logic [15:0] w, logic [7:0] st);
        case (s)
            2'b01:   return a0 ? 16'h006A : 16'h00C2;   // R5
            2'b10:   return {8'h00, st};                // R6
            default: return w;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    function automatic string classify();
        if (ce_n || oe_n)   return "R1";
        if (src == 2'b10)   return "R7";
        if (src == 2'b01)   return "R5";
        if (byte_mode)      return "R4";
        return "R2";
    endfunction

    // one cycle: model at the rising edge, compare at the next falling edge
    task automatic step(string tag);
        bit         act;
        logic [15:0] w;
        bit          r3_case;
        @(posedge clk);
        act = !ce_n && !oe_n;
        if (act && !m_prev_act) m_snap = {stat_ready, 2'b00, stat_fail, 4'b0000};
        m_prev_act = act;
        w = src_word(src, addr0, rd_word, m_snap);
        r3_case = act && byte_mode;
        if (!act) begin
            exp_l = 2'b00; exp_d = 16'h0;
        end else if (byte_mode) begin
            exp_l = 2'b01; exp_d = {8'h00, top_pin ? w[15:8] : w[7:0]};
        end else begin
            exp_l = 2'b11; exp_d = w;
        end
        @(negedge clk);
        check({tag, " lanes"}, 32'(lane_en), 32'(exp_l));
        check({tag, " data"},  32'(dout),    32'(exp_d));
        if (r3_case) check("R3 high lane", {30'b0, lane_en[1]} | 32'(dout[15:8]), 32'h0);
    endtask

    task automatic rand_step();
        if ($urandom_range(3) == 0) ce_n = ~ce_n;
        if ($urandom_range(3) == 0) oe_n = ~oe_n;
        if ($urandom_range(15) == 0) byte_mode = ~byte_mode;
        top_pin    = 1'($urandom);
        addr0      = 1'($urandom);
        src        = 2'($urandom);
        rd_word    = 16'($urandom);
        stat_ready = 1'($urandom);
        stat_fail  = 1'($urandom);
        step(classify());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; byte_mode = 1'b0; top_pin = 1'b0;
        src = 2'b00; addr0 = 1'b0; rd_word = 16'h0; stat_ready = 1'b0; stat_fail = 1'b0;
        m_prev_act = 1'b0; m_snap = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset lanes", 32'(lane_en), 32'h0);
        check("R8 reset data",  32'(dout),    32'h0);

        // R8: one cycle latency, R2 word mode with bit 15 set
        rd_word = 16'hA55A; ce_n = 1'b0; step("R8 latency");
        oe_n = 1'b0; step("R2 word");
        oe_n = 1'b1; step("R1 oe high");
        oe_n = 1'b0; ce_n = 1'b1; step("R1 ce high");
        // R4 / R3 byte steering
        ce_n = 1'b0; byte_mode = 1'b1; rd_word = 16'h8E31;
        top_pin = 1'b1; step("R4 upper");
        top_pin = 1'b0; step("R4 lower");
        // R5 identifier codes, both widths
        src = 2'b01; byte_mode = 1'b0; addr0 = 1'b0; step("R5 mfr");
        addr0 = 1'b1; step("R5 dev");
        byte_mode = 1'b1; top_pin = 1'b1; step("R5 upper byte");
        // R6 / R7 status capture and hold
        byte_mode = 1'b0; top_pin = 1'b0; src = 2'b10;
        oe_n = 1'b1; stat_ready = 1'b0; stat_fail = 1'b1; step("R1 idle");
        oe_n = 1'b0; step("R6 capture");
        stat_ready = 1'b1; stat_fail = 1'b0; step("R7 hold");
        step("R7 hold again");
        ce_n = 1'b1; step("R1 ce toggle");
        ce_n = 1'b0; step("R7 new value");
        // R7 capture while another source is selected
        oe_n = 1'b1; step("R1 idle");
        src = 2'b00; stat_ready = 1'b0; stat_fail = 1'b1; oe_n = 1'b0; step("R2 array");
        stat_ready = 1'b1; src = 2'b10; step("R7 snapshot from array access");
        src = 2'b11; step("R6 alt src");

        for (int i = 0; i < 4000; i++) rand_step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule